// File: doc/BRIEF.md
# Shift, Rotate and Bit-Manipulation Unit

This is a purely combinational datapath slice that carries out the extended bit-manipulation instruction group of an 8-bit processor core, along with the four accumulator rotates. The decoder gives it three things: a 2-bit group selector, a 3-bit field, and the operand byte. The 3-bit field names the rotate/shift operation in the first group and the bit index in the other three. The unit returns the new byte, a write-back enable and the updated flag nibble. The register file and the memory interface fetch the operand and store the result; that work happens outside the unit.

An accumulator-form select input marks the short rotate forms. For these, the zero flag is always cleared rather than derived from the result. The unit also reports the machine-cycle cost of the operation. The cost is two cycles, or four when the register index names the memory-indirect operand (index 6). The sequencer can use this value directly.

Top module: `bitshift_unit`

## Requirements
- R1: With group 0 (rotate/shift), the op field selects: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left arithmetic (bit 0 becomes 0), 5 shift right arithmetic, 6 nibble swap, 7 shift right logical. `result_out` carries the shifted byte.
- R2: Every group-0 operation clears N and H. C receives the bit shifted out: bit 7 for left moves, bit 0 for right moves, and 0 for swap. Rotates through carry put the incoming C into the vacated bit. The flag nibble is {Z,N,H,C}, with Z at bit 3, N at bit 2, H at bit 1 and C at bit 0.
- R3: Shift right arithmetic keeps bit 7 at its old value. Shift right logical makes bit 7 zero.
- R4: Nibble swap exchanges bits 7:4 with bits 3:0 and clears C.
- R5: For group 0 with `acc_form` low, Z is 1 exactly when the result byte is zero.
- R6: For group 0 with `acc_form` high, Z is 0 whatever the result.
- R7: Group 1 (bit test) checks bit `op_sel` of the operand. It sets Z when that bit is 0, sets H, clears N and keeps C. `result_out` equals the operand and `wr_en` is low.
- R8: Group 2 clears bit `op_sel` and group 3 sets it. All other bits pass through, and `flags_out` equals `flags_in`.
- R9: `wr_en` is high for groups 0, 2 and 3.
- R10: `mcycles` is 2, or 4 when `reg_idx` is 6, in every group.
- R11: `acc_form` has no effect on the outputs for groups 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| grp_sel | input | 2 | Group: 0 rotate/shift, 1 bit test, 2 bit clear, 3 bit set |
| op_sel | input | 3 | Shift operation code, or bit index |
| reg_idx | input | 3 | Operand register index; 6 is the memory operand |
| acc_form | input | 1 | Short accumulator rotate form (Z forced to 0) |
| operand_in | input | 8 | Operand byte |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| result_out | output | 8 | Result byte |
| wr_en | output | 1 | Write result back to the operand location |
| flags_out | output | 4 | Outgoing flags {Z,N,H,C} |
| mcycles | output | 3 | Machine-cycle cost |

## Verification
The unit has no registers, so every output is due in the same cycle its inputs are applied, zero clock edges later. The bench changes all inputs just after a falling clock edge. It then samples the result, the write enable, the flags and the cycle cost a quarter period later, well before the next rising edge. This keeps every check clear of edge ordering. Expected values come from bench functions that restate each operation through integer arithmetic. Seeded random vectors are mixed with directed corner cases such as the sign bit, the all-zero results and index 6.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLEAR = 2'd2,
    GRP_SETB  = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_RLC  = 3'd0,
    SH_RRC  = 3'd1,
    SH_RL   = 3'd2,
    SH_RR   = 3'd3,
    SH_SLA  = 3'd4,
    SH_SRA  = 3'd5,
    SH_SWAP = 3'd6,
    SH_SRL  = 3'd7
  } shop_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

endpackage

// File: rtl/sbu_shifter.sv
module sbu_shifter #(
  parameter int DW = 8
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] din,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          cout
);
  import sbu_pkg::*;

  localparam int HALF = DW / 2;

  function automatic logic [DW:0] do_shift(input logic [2:0] code,
                                           input logic [DW-1:0] a,
                                           input logic c);
    logic [DW-1:0] r;
    logic          co;
    case (shop_e'(code))
      SH_RLC:  begin r = {a[DW-2:0], a[DW-1]}; co = a[DW-1]; end
      SH_RRC:  begin r = {a[0], a[DW-1:1]};    co = a[0];    end
      SH_RL:   begin r = {a[DW-2:0], c};       co = a[DW-1]; end
      SH_RR:   begin r = {c, a[DW-1:1]};       co = a[0];    end
      SH_SLA:  begin r = {a[DW-2:0], 1'b0};    co = a[DW-1]; end
      SH_SRA:  begin r = {a[DW-1], a[DW-1:1]}; co = a[0];    end
      SH_SWAP: begin r = {a[HALF-1:0], a[DW-1:HALF]}; co = 1'b0; end
      default: begin r = {1'b0, a[DW-1:1]};    co = a[0];    end
    endcase
    return {co, r};
  endfunction

  always_comb begin
    {cout, dout} = do_shift(op, din, cin);
  end

endmodule

// File: rtl/sbu_bitop.sv
module sbu_bitop #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic [1:0]    grp,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          bit_zero
);
  import sbu_pkg::*;

  function automatic logic [DW-1:0] one_hot(input logic [IW-1:0] i);
    logic [DW-1:0] m;
    m = '0;
    m[i] = 1'b1;
    return m;
  endfunction

  logic [DW-1:0] mask;

  always_comb begin
    mask     = one_hot(idx);
    bit_zero = ~|(din & mask);
    case (grp_e'(grp))
      GRP_CLEAR: dout = din & ~mask;
      GRP_SETB:  dout = din | mask;
      default:   dout = din;
    endcase
  end

endmodule

// File: rtl/sbu_cost.sv
module sbu_cost #(
  parameter int MEM_IDX   = 6,
  parameter int BASE_CYC  = 2,
  parameter int EXTRA_CYC = 2,
  parameter int CW        = 3
) (
  input  logic [2:0]    reg_idx,
  output logic [CW-1:0] cycles
);
  localparam logic [CW-1:0] C_REG = CW'(BASE_CYC);
  localparam logic [CW-1:0] C_MEM = CW'(BASE_CYC + EXTRA_CYC);

  always_comb begin
    cycles = (reg_idx == 3'(MEM_IDX)) ? C_MEM : C_REG;
  end

endmodule

// File: rtl/bitshift_unit.sv
module bitshift_unit #(
  parameter int DW        = 8,
  parameter int MEM_IDX   = 6,
  parameter int BASE_CYC  = 2,
  parameter int EXTRA_CYC = 2,
  localparam int IW       = $clog2(DW),
  localparam int CW       = $clog2(BASE_CYC + EXTRA_CYC + 1)
) (
  input  logic [1:0]    grp_sel,
  input  logic [IW-1:0] op_sel,
  input  logic [2:0]    reg_idx,
  input  logic          acc_form,
  input  logic [DW-1:0] operand_in,
  input  logic [3:0]    flags_in,
  output logic [DW-1:0] result_out,
  output logic          wr_en,
  output logic [3:0]    flags_out,
  output logic [CW-1:0] mcycles
);
  import sbu_pkg::*;

  logic [DW-1:0] shift_res;
  logic          shift_c;
  logic [DW-1:0] bit_res;
  logic          bit_zero;
  flags_t        fin;
  flags_t        fout;

  assign fin = flags_t'(flags_in);

  sbu_shifter #(.DW(DW)) u_shift (
    .op   (op_sel[2:0]),
    .din  (operand_in),
    .cin  (fin.c),
    .dout (shift_res),
    .cout (shift_c)
  );

  sbu_bitop #(.DW(DW)) u_bit (
    .grp      (grp_sel),
    .idx      (op_sel),
    .din      (operand_in),
    .dout     (bit_res),
    .bit_zero (bit_zero)
  );

  sbu_cost #(
    .MEM_IDX   (MEM_IDX),
    .BASE_CYC  (BASE_CYC),
    .EXTRA_CYC (EXTRA_CYC),
    .CW        (CW)
  ) u_cost (
    .reg_idx (reg_idx),
    .cycles  (mcycles)
  );

  always_comb begin
    fout       = fin;
    result_out = bit_res;
    wr_en      = 1'b1;
    case (grp_e'(grp_sel))
      GRP_SHIFT: begin
        result_out = shift_res;
        fout.z     = acc_form ? 1'b0 : ~|shift_res;
        fout.n     = 1'b0;
        fout.h     = 1'b0;
        fout.c     = shift_c;
      end
      GRP_TEST: begin
        wr_en  = 1'b0;
        fout.z = bit_zero;
        fout.n = 1'b0;
        fout.h = 1'b1;
      end
      default: ;
    endcase
    flags_out = fout;
  end

endmodule

// File: rtl/sbu_checker.sv
module sbu_checker #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic [1:0]    grp_sel,
  input logic [2:0]    reg_idx,
  input logic          acc_form,
  input logic [DW-1:0] operand_in,
  input logic [3:0]    flags_in,
  input logic [DW-1:0] result_out,
  input logic          wr_en,
  input logic [3:0]    flags_out,
  input logic [CW-1:0] mcycles,
  input logic [DW-1:0] shift_res,
  input logic          bit_zero
);
  always_comb begin
    // R7: bit test never writes and returns the operand
    a_r7_test_no_write: assert (grp_sel != 2'd1 ||
      (!wr_en && result_out == operand_in && flags_out[1] && !flags_out[2]
       && flags_out[0] == flags_in[0] && flags_out[3] == bit_zero));
    // R9: the other groups write back
    a_r9_write_other: assert (grp_sel == 2'd1 || wr_en);
    // R8: clear/set leave flags untouched
    a_r8_flags_kept: assert (grp_sel < 2'd2 || flags_out == flags_in);
    // R2: rotate/shift clears N and H
    a_r2_nh_clear: assert (grp_sel != 2'd0 || flags_out[2:1] == 2'b00);
    // R6: accumulator form forces Z low
    a_r6_acc_z_low: assert (grp_sel != 2'd0 || !acc_form || !flags_out[3]);
    // R5: prefixed form Z tracks a zero result
    a_r5_z_result: assert (grp_sel != 2'd0 || acc_form ||
      flags_out[3] == (shift_res == '0));
    // R10: cost is one of the two legal values, tied to the index
    a_r10_cost: assert (mcycles == ((reg_idx == 3'd6) ? CW'(4) : CW'(2)));
  end
endmodule

bind bitshift_unit sbu_checker #(.DW(DW), .CW(CW)) u_chk (
  .grp_sel    (grp_sel),
  .reg_idx    (reg_idx),
  .acc_form   (acc_form),
  .operand_in (operand_in),
  .flags_in   (flags_in),
  .result_out (result_out),
  .wr_en      (wr_en),
  .flags_out  (flags_out),
  .mcycles    (mcycles),
  .shift_res  (shift_res),
  .bit_zero   (bit_zero)
);

// File: tb/tb_bitshift_unit.sv
module tb_bitshift_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] grp_sel = '0;
  logic [2:0] op_sel = '0;
  logic [2:0] reg_idx = '0;
  logic       acc_form = 1'b0;
  logic [7:0] operand_in = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] result_out;
  logic       wr_en;
  logic [3:0] flags_out;
  logic [2:0] mcycles;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitshift_unit dut (
    .grp_sel(grp_sel), .op_sel(op_sel), .reg_idx(reg_idx),
    .acc_form(acc_form), .operand_in(operand_in), .flags_in(flags_in),
    .result_out(result_out), .wr_en(wr_en), .flags_out(flags_out),
    .mcycles(mcycles)
  );

  // Reference model in integer arithmetic
  function automatic int ref_res(int g, int y, int a, int f);
    int c = f & 1;
    if (g == 0) begin
      case (y)
        0: return ((a * 2) + (a / 128)) % 256;
        1: return (a / 2) + (a % 2) * 128;
        2: return ((a * 2) + c) % 256;
        3: return (a / 2) + c * 128;
        4: return (a * 2) % 256;
        5: return (a / 2) + (a / 128) * 128;
        6: return (a % 16) * 16 + (a / 16);
        default: return a / 2;
      endcase
    end
    if (g == 1) return a;
    if (g == 2) return (a / (2 ** (y + 1))) * (2 ** (y + 1)) + (a % (2 ** y));
    return ((a / (2 ** y)) % 2 == 1) ? a : a + (2 ** y);
  endfunction

  function automatic int ref_flags(int g, int y, int a, int f, int acc);
    int r = ref_res(g, y, a, f);
    int co;
    if (g == 0) begin
      if (y == 6) co = 0;
      else if (y == 0 || y == 2 || y == 4) co = a / 128;
      else co = a % 2;
      return ((acc == 0 && r == 0) ? 8 : 0) + co;
    end
    if (g == 1)
      return ((((a / (2 ** y)) % 2) == 0) ? 8 : 0) + 2 + (f % 2);
    return f;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply_and_check(int g, int y, int ri, int acc, int a, int f);
    string tr;
    string tf;
    @(negedge clk);
    grp_sel = 2'(g); op_sel = 3'(y); reg_idx = 3'(ri);
    acc_form = 1'(acc); operand_in = 8'(a); flags_in = 4'(f);
    #(CLK_PERIOD/4);
    tr = (g == 0) ? "R1" : (g == 1 ? "R7" : "R8");
    tf = (g == 0) ? (acc != 0 ? "R2/R6" : "R2/R5") : (g == 1 ? "R7" : "R8");
    if (acc != 0 && g != 0) begin tr = {tr, "/R11"}; tf = {tf, "/R11"}; end
    chk(tr, "result", int'(result_out), ref_res(g, y, a, f));
    chk(tf, "flags", int'(flags_out), ref_flags(g, y, a, f, acc));
    chk((g == 1) ? "R7" : "R9", "wr_en", int'(wr_en), (g == 1) ? 0 : 1);
    chk("R10", "mcycles", int'(mcycles), (ri == 6) ? 4 : 2);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs, rotate of zero
    @(negedge clk);
    #(CLK_PERIOD/4);
    chk("R5", "idle flags", int'(flags_out), 8);
    chk("R10", "idle mcycles", int'(mcycles), 2);
    // R3 corner cases
    apply_and_check(0, 5, 0, 0, 8'h81, 0);
    chk("R3", "sra keeps bit7", int'(result_out), 8'hC0);
    apply_and_check(0, 7, 0, 0, 8'h81, 0);
    chk("R3", "srl clears bit7", int'(result_out), 8'h40);
    // R4 swap with carry set in
    apply_and_check(0, 6, 6, 0, 8'hA5, 1);
    chk("R4", "swap", int'(result_out), 8'h5A);
    chk("R4", "swap carry", int'(flags_out[0]), 0);
    // R2 carry into rotate through carry
    apply_and_check(0, 2, 1, 0, 8'h80, 1);
    chk("R2", "rl old carry in", int'(result_out), 8'h01);
    apply_and_check(0, 3, 1, 0, 8'h01, 1);
    chk("R2", "rr old carry in", int'(result_out), 8'h80);
    // R5 / R6 zero results
    apply_and_check(0, 4, 2, 0, 8'h80, 0);
    chk("R5", "zero result Z", int'(flags_out[3]), 1);
    apply_and_check(0, 4, 2, 1, 8'h80, 0);
    chk("R6", "acc form Z", int'(flags_out[3]), 0);
    // R7 bit test, zero and one
    apply_and_check(1, 7, 6, 0, 8'h7F, 1);
    apply_and_check(1, 0, 3, 0, 8'h01, 0);
    // R8 clear / set on edge bits
    apply_and_check(2, 7, 6, 0, 8'hFF, 4'hF);
    apply_and_check(3, 0, 5, 0, 8'h00, 4'h0);
    // R11 acc form on other groups
    apply_and_check(1, 3, 0, 1, 8'h00, 0);
    apply_and_check(3, 5, 0, 1, 8'h00, 4'h5);
    for (int k = 0; k < 600; k++) begin
      apply_and_check($urandom % 4, $urandom % 8, $urandom % 8,
                      $urandom % 2, $urandom % 256, $urandom % 16);
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule